// File: doc/BRIEF.md
# Region-Granular Way Steering and Prediction

This block serves a set-associative cache that stores its tags alongside the data, where reading every way to find a line is too costly. It treats each memory page as a region and remembers, for a small number of recently active regions, which way the region last used. One table holds the way of the most recent install per region; the cache's fill logic queries it so that later lines of the same region go into that same way. A second table holds the way of the most recent confirmed hit per region; the lookup path queries it to choose the single way it reads first. Streams with good spatial locality therefore keep landing in, and being predicted to, one way per page.

A query presents an address and returns both the steered install way and the predicted way two clocks later. Each answer carries a flag that says whether a table entry matched. When no entry matches, the way returned is the region's static preferred way. The caller can then apply its own biased-install choice or its static prediction. The install table is updated by install events and the lookup table by hit events, in the cycle each event is presented. Both tables are direct-indexed by the low bits of the region number and tagged with the remaining region bits.

Top module: `region_way_steer`

## Requirements
- R1: A synchronous active-high reset invalidates every entry of both tables and clears rsp_valid, inst_hit and pred_hit. Entries become invalid only through reset.
- R2: The region of an address is addr[ADDR_W-1:PAGE_W]. The low PAGE_W page-offset bits have no effect on any result.
- R3: Each table has 2**IDX_W entries, indexed by region[IDX_W-1:0], and stores region[REGION_W-1:IDX_W] as its tag. A new update overwrites the indexed entry. A region sharing the index but not the tag then misses.
- R4: When the queried region matches a valid install-table entry, inst_hit is 1 and inst_way is the stored way. Otherwise inst_hit is 0 and inst_way is the preferred way, region[WAY_W-1:0].
- R5: When the queried region matches a valid lookup-table entry, pred_hit is 1 and pred_way is the stored way. Otherwise pred_hit is 0 and pred_way is the preferred way, region[WAY_W-1:0].
- R6: An install event (ins_en) writes only the install table. A hit event (hit_en) writes only the lookup table.
- R7: A query and an update of the same entry in the same cycle return the entry's previous contents. The update is seen by a query in the next cycle.
- R8: The result of a query sampled at clock edge n appears on the outputs after edge n+2. rsp_valid is high for exactly that one cycle and low whenever no query was made two edges before.
- R9: WAY_W sets the way-index width and may be 1, 2 or 3, covering 2-way to 8-way caches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| q_valid | input | 1 | Query strobe |
| q_addr | input | ADDR_W | Address being queried |
| ins_en | input | 1 | Install event strobe |
| ins_addr | input | ADDR_W | Address of the installed line |
| ins_way | input | WAY_W | Way the line was installed into |
| hit_en | input | 1 | Confirmed hit event strobe |
| hit_addr | input | ADDR_W | Address of the line that hit |
| hit_way | input | WAY_W | Way where the hit was found |
| rsp_valid | output | 1 | Query result valid |
| inst_hit | output | 1 | Install-table entry matched |
| inst_way | output | WAY_W | Steered install way, or the preferred way on a miss |
| pred_hit | output | 1 | Lookup-table entry matched |
| pred_way | output | WAY_W | Predicted way, or the preferred way on a miss |

## Verification
The bench goes after index aliasing first. A design that compared too few tag bits would report a hit for a foreign region that shares the index, and one that failed to overwrite would keep predicting the old way. It also presents a query and an update of the same entry in one cycle. A write-first memory would return the new way a cycle early there, and a missing write path would leave the next query missing. Further sweeps check that installs and hits each fill only their own table, that page-offset bits never change a result, and that a reset in the middle of a run forgets every region. A design leaking across tables would show a hit on the wrong flag, and one that kept its valid bits through reset would still hit after it.

// File: rtl/rws_pkg.sv
package rws_pkg;
  localparam int MIN_WAY_W = 1;
  localparam int MAX_WAY_W = 3;
  localparam int RD_LATENCY = 2;

  function automatic bit way_w_ok(input int w);
    return (w >= MIN_WAY_W) && (w <= MAX_WAY_W);
  endfunction
endpackage

// File: rtl/rws_region.sv
module rws_region #(
  parameter int REGION_W = 20,
  parameter int IDX_W    = 6,
  parameter int WAY_W    = 1,
  localparam int TAG_W   = REGION_W - IDX_W
) (
  input  logic [REGION_W-1:0] region,
  output logic [IDX_W-1:0]    idx,
  output logic [TAG_W-1:0]    tag,
  output logic [WAY_W-1:0]    pref
);
  assign idx  = region[IDX_W-1:0];
  assign tag  = region[REGION_W-1:IDX_W];
  assign pref = region[WAY_W-1:0];
endmodule

// File: rtl/rws_table.sv
module rws_table #(
  parameter int IDX_W   = 6,
  parameter int TAG_W   = 14,
  parameter int WAY_W   = 1,
  localparam int DEPTH  = 1 << IDX_W,
  localparam int ENT_W  = TAG_W + WAY_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [TAG_W-1:0] rd_tag,
  input  logic [WAY_W-1:0] rd_pref,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [WAY_W-1:0] wr_way,
  output logic             out_hit,
  output logic [WAY_W-1:0] out_way
);
  logic [ENT_W-1:0] mem [DEPTH];
  logic [ENT_W-1:0] mem_q;
  logic [DEPTH-1:0] vld;
  logic             s1_rd;
  logic             s1_vbit;
  logic [TAG_W-1:0] s1_tag;
  logic [WAY_W-1:0] s1_pref;
  logic             match;

  // storage without reset, read-before-write for block RAM inference
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= {wr_tag, wr_way};
    if (rd_en) mem_q <= mem[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld     <= '0;
      s1_rd   <= 1'b0;
      s1_vbit <= 1'b0;
      s1_tag  <= '0;
      s1_pref <= '0;
    end else begin
      if (wr_en) vld[wr_idx] <= 1'b1;
      s1_rd <= rd_en;
      if (rd_en) begin
        s1_vbit <= vld[rd_idx];
        s1_tag  <= rd_tag;
        s1_pref <= rd_pref;
      end
    end
  end

  assign match = s1_vbit && (mem_q[ENT_W-1:WAY_W] == s1_tag);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_hit <= 1'b0;
      out_way <= '0;
    end else if (s1_rd) begin
      out_hit <= match;
      out_way <= match ? mem_q[WAY_W-1:0] : s1_pref;
    end
  end

  // entries are never dropped outside reset
  assert_valid_keep_R1: assert property (@(posedge clk) disable iff (rst)
    $countones(vld) >= $countones($past(vld)));

  // an update is seen by a read of the same region one cycle later
  assert_write_visible_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_en && $past(wr_en) && rd_idx == $past(wr_idx) && rd_tag == $past(wr_tag))
    |=> ##1 (out_hit && out_way == $past(wr_way, 3)));
endmodule

// File: rtl/region_way_steer.sv
module region_way_steer #(
  parameter int ADDR_W   = 32,
  parameter int PAGE_W   = 12,
  parameter int IDX_W    = 6,
  parameter int WAY_W    = 1,
  localparam int REGION_W = ADDR_W - PAGE_W,
  localparam int TAG_W    = REGION_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              q_valid,
  input  logic [ADDR_W-1:0] q_addr,
  input  logic              ins_en,
  input  logic [ADDR_W-1:0] ins_addr,
  input  logic [WAY_W-1:0]  ins_way,
  input  logic              hit_en,
  input  logic [ADDR_W-1:0] hit_addr,
  input  logic [WAY_W-1:0]  hit_way,
  output logic              rsp_valid,
  output logic              inst_hit,
  output logic [WAY_W-1:0]  inst_way,
  output logic              pred_hit,
  output logic [WAY_W-1:0]  pred_way
);
  logic [IDX_W-1:0] q_idx, i_idx, h_idx;
  logic [TAG_W-1:0] q_tag, i_tag, h_tag;
  logic [WAY_W-1:0] q_pref, i_pref_unused, h_pref_unused;
  logic             rsp_s1;
  logic             unused_offsets;

  assign unused_offsets = ^{q_addr[PAGE_W-1:0], ins_addr[PAGE_W-1:0],
                            hit_addr[PAGE_W-1:0], i_pref_unused, h_pref_unused};

  rws_region #(.REGION_W(REGION_W), .IDX_W(IDX_W), .WAY_W(WAY_W)) u_q_reg (
    .region(q_addr[ADDR_W-1:PAGE_W]), .idx(q_idx), .tag(q_tag), .pref(q_pref));
  rws_region #(.REGION_W(REGION_W), .IDX_W(IDX_W), .WAY_W(WAY_W)) u_i_reg (
    .region(ins_addr[ADDR_W-1:PAGE_W]), .idx(i_idx), .tag(i_tag), .pref(i_pref_unused));
  rws_region #(.REGION_W(REGION_W), .IDX_W(IDX_W), .WAY_W(WAY_W)) u_h_reg (
    .region(hit_addr[ADDR_W-1:PAGE_W]), .idx(h_idx), .tag(h_tag), .pref(h_pref_unused));

  rws_table #(.IDX_W(IDX_W), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_install_tbl (
    .clk(clk), .rst(rst),
    .rd_en(q_valid), .rd_idx(q_idx), .rd_tag(q_tag), .rd_pref(q_pref),
    .wr_en(ins_en), .wr_idx(i_idx), .wr_tag(i_tag), .wr_way(ins_way),
    .out_hit(inst_hit), .out_way(inst_way));

  rws_table #(.IDX_W(IDX_W), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_lookup_tbl (
    .clk(clk), .rst(rst),
    .rd_en(q_valid), .rd_idx(q_idx), .rd_tag(q_tag), .rd_pref(q_pref),
    .wr_en(hit_en), .wr_idx(h_idx), .wr_tag(h_tag), .wr_way(hit_way),
    .out_hit(pred_hit), .out_way(pred_way));

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_s1    <= 1'b0;
      rsp_valid <= 1'b0;
    end else begin
      rsp_s1    <= q_valid;
      rsp_valid <= rsp_s1;
    end
  end

  initial begin
    assert_way_width_R9: assert (rws_pkg::way_w_ok(WAY_W));
  end

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!rsp_valid && !inst_hit && !pred_hit));

  assert_rsp_timing_R8: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(q_valid, rws_pkg::RD_LATENCY));

  assert_inst_pref_R4: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !inst_hit) |-> inst_way == $past(q_addr[PAGE_W +: WAY_W], 2));

  assert_pred_pref_R5: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !pred_hit) |-> pred_way == $past(q_addr[PAGE_W +: WAY_W], 2));
endmodule

// File: tb/tb_region_way_steer.sv
`timescale 1ns/1ps
module tb_region_way_steer;
  localparam int AW = 24;
  localparam int PW = 12;
  localparam int IW = 6;
  localparam int WW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic q_valid = 1'b0, ins_en = 1'b0, hit_en = 1'b0;
  logic [AW-1:0] q_addr = '0, ins_addr = '0, hit_addr = '0;
  logic [WW-1:0] ins_way = '0, hit_way = '0;
  logic rsp_valid, inst_hit, pred_hit;
  logic [WW-1:0] inst_way, pred_way;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // model of both tables
  bit       mi_v [64];
  bit [5:0] mi_t [64];
  bit [1:0] mi_w [64];
  bit       ml_v [64];
  bit [5:0] ml_t [64];
  bit [1:0] ml_w [64];

  always #2.5 clk = ~clk;

  region_way_steer #(.ADDR_W(AW), .PAGE_W(PW), .IDX_W(IW), .WAY_W(WW)) dut (
    .clk(clk), .rst(rst), .q_valid(q_valid), .q_addr(q_addr),
    .ins_en(ins_en), .ins_addr(ins_addr), .ins_way(ins_way),
    .hit_en(hit_en), .hit_addr(hit_addr), .hit_way(hit_way),
    .rsp_valid(rsp_valid), .inst_hit(inst_hit), .inst_way(inst_way),
    .pred_hit(pred_hit), .pred_way(pred_way));

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] mk(input int tag, input int idx, input int off);
    return {tag[5:0], idx[5:0], off[11:0]};
  endfunction

  task automatic clear_model();
    for (int i = 0; i < 64; i++) begin
      mi_v[i] = 1'b0; ml_v[i] = 1'b0;
    end
  endtask

  task automatic do_reset(input string req);
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    clear_model();
    chk(req, "rsp_valid after reset", int'(rsp_valid), 0);
    chk(req, "inst_hit after reset", int'(inst_hit), 0);
    chk(req, "pred_hit after reset", int'(pred_hit), 0);
  endtask

  task automatic step(input bit qv, input logic [AW-1:0] qa,
                      input bit iv, input logic [AW-1:0] ia, input int iw,
                      input bit hv, input logic [AW-1:0] ha, input int hw,
                      input string req);
    int qi, qt, pr, e_ih, e_iw, e_ph, e_pw;
    qi = int'(qa[PW +: 6]);
    qt = int'(qa[PW+6 +: 6]);
    pr = int'(qa[PW +: WW]);
    e_ih = (mi_v[qi] && mi_t[qi] == qt[5:0]) ? 1 : 0;
    e_iw = e_ih ? int'(mi_w[qi]) : pr;
    e_ph = (ml_v[qi] && ml_t[qi] == qt[5:0]) ? 1 : 0;
    e_pw = e_ph ? int'(ml_w[qi]) : pr;
    @(negedge clk);
    q_valid = qv; q_addr = qa;
    ins_en = iv; ins_addr = ia; ins_way = iw[1:0];
    hit_en = hv; hit_addr = ha; hit_way = hw[1:0];
    if (iv) begin
      mi_v[ia[PW +: 6]] = 1'b1; mi_t[ia[PW +: 6]] = ia[PW+6 +: 6]; mi_w[ia[PW +: 6]] = iw[1:0];
    end
    if (hv) begin
      ml_v[ha[PW +: 6]] = 1'b1; ml_t[ha[PW +: 6]] = ha[PW+6 +: 6]; ml_w[ha[PW +: 6]] = hw[1:0];
    end
    @(negedge clk);
    q_valid = 1'b0; ins_en = 1'b0; hit_en = 1'b0;
    chk("R8", "rsp_valid one cycle after query", int'(rsp_valid), 0);
    @(negedge clk);
    chk("R8", "rsp_valid two cycles after query", int'(rsp_valid), qv ? 1 : 0);
    if (qv) begin
      chk(req, "inst_hit", int'(inst_hit), e_ih);
      chk(req, "inst_way", int'(inst_way), e_iw);
      chk(req, "pred_hit", int'(pred_hit), e_ph);
      chk(req, "pred_way", int'(pred_way), e_pw);
    end
  endtask

  task automatic query(input logic [AW-1:0] qa, input string req);
    step(1'b1, qa, 1'b0, '0, 0, 1'b0, '0, 0, req);
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        bad++; total++;
        $display("FAIL watchdog R8 actual=%0d expected=%0d", cyc, 100000);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    do_reset("R1");

    // empty tables: every region misses and returns its preferred way
    for (int r = 0; r < 64; r++)
      query(mk((r * 5) % 64, r, r * 61), "R4 R5 empty");

    // install sweep, then query with other page offsets
    for (int i = 0; i < 64; i++)
      step(1'b0, '0, 1'b1, mk(i ^ 21, i, 0), (i * 3) % 4, 1'b0, '0, 0, "R6 install");
    for (int i = 0; i < 64; i++)
      query(mk(i ^ 21, i, (i * 37) % 4096), "R2 R4 R6 offset");

    // hit sweep: even indices same region as install, odd a different tag
    for (int i = 0; i < 64; i++)
      step(1'b0, '0, 1'b0, '0, 0, 1'b1,
           mk((i % 2 == 0) ? (i ^ 21) : (i ^ 42), i, 4095), (i + 1) % 4, "R6 hit");
    for (int i = 0; i < 64; i++)
      query(mk(i ^ 21, i, 7), "R5 R6 lookup");
    for (int i = 1; i < 64; i += 2)
      query(mk(i ^ 42, i, 100), "R3 R5 alias");

    // aliasing and overwrite on one index
    step(1'b0, '0, 1'b1, mk(3, 5, 0), 1, 1'b0, '0, 0, "R3 write A");
    query(mk(9, 5, 0), "R3 foreign tag");
    step(1'b0, '0, 1'b1, mk(9, 5, 0), 2, 1'b0, '0, 0, "R3 write B");
    query(mk(9, 5, 0), "R3 new tag");
    query(mk(3, 5, 0), "R3 old tag evicted");

    // same-cycle query and update of the same entry
    step(1'b1, mk(9, 5, 0), 1'b1, mk(9, 5, 1), 3, 1'b1, mk(9, 5, 2), 0, "R7 same cycle");
    query(mk(9, 5, 3), "R7 next cycle");
    step(1'b1, mk(11, 40, 0), 1'b1, mk(11, 40, 0), 2, 1'b1, mk(11, 40, 0), 1, "R7 new entry");
    query(mk(11, 40, 0), "R7 new entry visible");

    // reset mid-run forgets all regions
    do_reset("R1 mid");
    for (int i = 0; i < 64; i++)
      query(mk(i ^ 21, i, 0), "R1 cleared");

    // wider way values on a few entries
    for (int w = 0; w < 4; w++) begin
      step(1'b0, '0, 1'b1, mk(w + 1, 60 + w, 0), w, 1'b1, mk(w + 1, 60 + w, 0), 3 - w, "R9 ways");
      query(mk(w + 1, 60 + w, 55), "R9 ways");
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule